// File: doc/BRIEF.md
# Host Byte Port with Buffer-Full Handshake

This block lets a host processor reach a 256-entry byte register space through only two byte-wide ports: a data port, and a port that returns status when read and accepts a command when written. Every access is a short conversation. The host writes an opcode to the command port, then writes a register address to the data port, and for a store it then writes the value as well. A load ends with the fetched byte waiting in the data port.

Two flags pace the conversation. The input-full flag is up while the block still holds a host byte it has not yet acted on. The output-full flag is up while a fetched byte waits for the host. A well-behaved host waits for input-full to drop before each write, and waits for output-full to rise before collecting a load result. The time the block takes to consume a byte is a parameter (`CONSUME_CYCLES`), so a slow internal controller can be modelled.

On the register side, the block drives a plain synchronous interface. A store is a single-cycle write enable carrying its address and data. A load is a single-cycle read enable, and the addressed byte returns on the read-data input one cycle later. The host side uses single-cycle read and write strobes together with a port select. There is no back-pressure other than the two flags.

Top module: `ec_host_port`

## Requirements
- R1: When the host selects the command/status port (`host_sel_cmd`=1), `host_rdata` reads the status byte: bit 1 is input-full, bit 0 is output-full, and bits 7..2 are zero.
- R2: A host write to either port raises input-full from the next cycle. The flag stays high for exactly `CONSUME_CYCLES` cycles after the write strobe and then drops.
- R3: The sequence opcode 0x80, then an address byte A, produces one single-cycle `reg_rd_en` with `reg_addr`=A. The byte returned one cycle later is placed in the data port, and output-full rises.
- R4: The sequence opcode 0x81, then address A, then value V, produces exactly one single-cycle `reg_we` with `reg_addr`=A and `reg_wdata`=V.
- R5: With `host_sel_cmd`=0, `host_rdata` shows the data-port byte. A host read strobe on the data port clears output-full.
- R6: A command byte other than 0x80 or 0x81 returns the sequencer to idle. Data bytes that follow it cause no register access and leave output-full low.
- R7: A command consumed in the middle of a sequence abandons that sequence and starts the new one. The abandoned store never writes.
- R8: A data-port byte consumed while idle is discarded, with no register access and no change to output-full.
- R9: Reset clears both flags and returns the sequencer to idle. A byte that was still pending when reset arrived is never acted on.
- R10: A host write while input-full is still high replaces the pending byte and restarts the consume delay. Only the newer byte is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_sel_cmd | input | 1 | Port select: 1 = command/status port, 0 = data port |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Status byte or data-port byte, as selected |
| reg_addr | output | ADDR_W | Register-space address |
| reg_wdata | output | 8 | Register-space write value |
| reg_we | output | 1 | Register-space write enable, one cycle |
| reg_rd_en | output | 1 | Register-space read enable, one cycle |
| reg_rdata | input | 8 | Register-space read value, valid the cycle after `reg_rd_en` |

## Verification
The bench targets the points where a sequencer of this kind usually goes wrong:
- **Input-full timing.** The bench counts the exact cycle in which input-full drops. A design with an off-by-one consume counter shortens or lengthens that window, and a host polling the flag would race it.
- **Aborted store.** An opcode arrives after a store's address but before its value. A design that keeps its old state would write to the abandoned address.
- **Overwritten pending byte.** A second address is written before the first is consumed. Only the second may be used.
- **Ignored bytes.** Unknown opcodes and stray data bytes must produce no register strobe and no output-full.
- **Clear on read.** If output-full were not cleared by a host read, a polling host would collect stale data.

// File: rtl/ec_port_pkg.sv
package ec_port_pkg;

  localparam int BYTE_W = 8;

  // opcode values written to the command port
  localparam logic [BYTE_W-1:0] OP_LOAD  = 8'h80;
  localparam logic [BYTE_W-1:0] OP_STORE = 8'h81;

  // status byte bit positions
  localparam int STS_IN_FULL  = 1;
  localparam int STS_OUT_FULL = 0;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LD_ADDR,
    SQ_ST_ADDR,
    SQ_ST_VALUE,
    SQ_FETCH,
    SQ_CAPTURE
  } seq_state_t;

endpackage

// File: rtl/ec_inbox.sv
// Holds the latest host byte and times its consumption.
module ec_inbox
  import ec_port_pkg::*;
#(
  parameter int CONSUME_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              wr_is_cmd,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic              in_full,
  output logic [BYTE_W-1:0] pend_byte,
  output logic              pend_is_cmd,
  output logic              take
);

  localparam int CNT_W = $clog2(CONSUME_CYCLES + 1);

  logic [CNT_W-1:0] wait_cnt;

  // the byte is handed over on the last cycle of its delay, unless replaced
  assign take = in_full && (wait_cnt == CNT_W'(1)) && !wr_stb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_full     <= 1'b0;
      wait_cnt    <= '0;
      pend_byte   <= '0;
      pend_is_cmd <= 1'b0;
    end else if (wr_stb) begin
      in_full     <= 1'b1;
      wait_cnt    <= CNT_W'(CONSUME_CYCLES);
      pend_byte   <= wr_byte;
      pend_is_cmd <= wr_is_cmd;
    end else if (take) begin
      in_full  <= 1'b0;
      wait_cnt <= '0;
    end else if (in_full) begin
      wait_cnt <= wait_cnt - CNT_W'(1);
    end
  end

  a_r2_set_on_write : assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> in_full);
  a_r2_hold_until_take : assert property (@(posedge clk) disable iff (!rst_n)
    (in_full && !take) |=> in_full);
  a_r10_no_take_on_write : assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !take);

endmodule

// File: rtl/ec_sequencer.sv
// Walks the opcode / address / value conversation and drives the register side.
module ec_sequencer
  import ec_port_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              pend_is_cmd,
  input  logic [BYTE_W-1:0] pend_byte,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_rd_en,
  output logic              load,
  output logic [BYTE_W-1:0] load_byte
);

  seq_state_t state;
  logic       cmd_take;
  logic       data_take;

  assign cmd_take  = take && pend_is_cmd;
  assign data_take = take && !pend_is_cmd;

  // a command arriving during capture abandons the fetched byte
  assign load      = (state == SQ_CAPTURE) && !cmd_take;
  assign load_byte = reg_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      reg_rd_en <= 1'b0;
    end else begin
      reg_we    <= 1'b0;
      reg_rd_en <= 1'b0;
      if (cmd_take) begin
        unique case (pend_byte)
          OP_LOAD:  state <= SQ_LD_ADDR;
          OP_STORE: state <= SQ_ST_ADDR;
          default:  state <= SQ_IDLE;
        endcase
      end else begin
        unique case (state)
          SQ_LD_ADDR: if (data_take) begin
            reg_addr  <= pend_byte[ADDR_W-1:0];
            reg_rd_en <= 1'b1;
            state     <= SQ_FETCH;
          end
          SQ_ST_ADDR: if (data_take) begin
            reg_addr <= pend_byte[ADDR_W-1:0];
            state    <= SQ_ST_VALUE;
          end
          SQ_ST_VALUE: if (data_take) begin
            reg_wdata <= pend_byte;
            reg_we    <= 1'b1;
            state     <= SQ_IDLE;
          end
          SQ_FETCH:   state <= SQ_CAPTURE;
          SQ_CAPTURE: state <= SQ_IDLE;
          default:    state <= SQ_IDLE;
        endcase
      end
    end
  end

  a_r4_we_single : assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  a_r3_rd_single : assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> !reg_rd_en);
  a_r4_we_rd_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_rd_en));
  a_r8_idle_quiet : assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_IDLE && !cmd_take) |=> (!reg_we && !reg_rd_en));
  a_r6_unknown_to_idle : assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_take && pend_byte != OP_LOAD && pend_byte != OP_STORE) |=> state == SQ_IDLE);
  a_r3_fetch_then_load : assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> state == SQ_CAPTURE || (state != SQ_FETCH));

endmodule

// File: rtl/ec_outbox.sv
// Holds the byte returned to the host and its output-full flag.
module ec_outbox
  import ec_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              rd_clr,
  output logic              out_full,
  output logic [BYTE_W-1:0] out_byte
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_full <= 1'b0;
      out_byte <= '0;
    end else if (load) begin
      out_full <= 1'b1;
      out_byte <= load_byte;
    end else if (rd_clr) begin
      out_full <= 1'b0;
    end
  end

  a_r5_read_clears : assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !load) |=> !out_full);
  a_r3_load_sets : assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (out_full && out_byte == $past(load_byte)));
  a_r5_byte_stable : assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(out_byte));

endmodule

// File: rtl/ec_host_port.sv
module ec_host_port
  import ec_port_pkg::*;
#(
  parameter int CONSUME_CYCLES = 3,
  parameter int ADDR_W         = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_sel_cmd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  output logic              reg_we,
  output logic              reg_rd_en,
  input  logic [7:0]        reg_rdata
);

  logic              in_full, out_full, take, pend_is_cmd, load;
  logic [BYTE_W-1:0] pend_byte, load_byte, out_byte, status;

  ec_inbox #(.CONSUME_CYCLES(CONSUME_CYCLES)) u_inbox (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (host_wr),
    .wr_is_cmd  (host_sel_cmd),
    .wr_byte    (host_wdata),
    .in_full    (in_full),
    .pend_byte  (pend_byte),
    .pend_is_cmd(pend_is_cmd),
    .take       (take)
  );

  ec_sequencer #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .pend_is_cmd(pend_is_cmd),
    .pend_byte  (pend_byte),
    .reg_rdata  (reg_rdata),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_we     (reg_we),
    .reg_rd_en  (reg_rd_en),
    .load       (load),
    .load_byte  (load_byte)
  );

  ec_outbox u_outbox (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_byte(load_byte),
    .rd_clr   (host_rd && !host_sel_cmd),
    .out_full (out_full),
    .out_byte (out_byte)
  );

  always_comb begin
    status               = '0;
    status[STS_IN_FULL]  = in_full;
    status[STS_OUT_FULL] = out_full;
  end

  assign host_rdata = host_sel_cmd ? status : out_byte;

  a_r1_status_upper_zero : assert property (@(posedge clk) disable iff (!rst_n)
    host_sel_cmd |-> host_rdata[7:2] == 6'd0);
  a_r9_flags_low_after_reset : assert property (@(posedge clk)
    !rst_n |=> (!in_full && !out_full));

endmodule

// File: tb/ec_host_port_bench.sv
module ec_host_port_bench;

  localparam int DLY = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0, host_sel_cmd = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_we, reg_rd_en;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ec_host_port #(.CONSUME_CYCLES(DLY), .ADDR_W(8)) u_ec_host_port (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel_cmd(host_sel_cmd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata)
  );

  // register space model and bench shadow copy
  logic [7:0] mem [256];
  logic [7:0] shadow [256];
  int we_cnt = 0, rd_cnt = 0;

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 8'(i) ^ 8'h5A;
      shadow[i] = 8'(i) ^ 8'h5A;
    end
    reg_rdata = 8'h00;
  end

  always @(posedge clk) begin
    if (reg_we) mem[reg_addr] <= reg_wdata;
    if (reg_rd_en) reg_rdata <= mem[reg_addr];
    if (rst_n && reg_we) we_cnt <= we_cnt + 1;
    if (rst_n && reg_rd_en) rd_cnt <= rd_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input bit sel, input logic [7:0] b);
    @(negedge clk);
    host_sel_cmd = sel; host_wdata = b; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic wait_in_empty();
    host_sel_cmd = 1'b1;
    for (int i = 0; i < 50; i++) begin
      #1;
      if (!host_rdata[1]) return;
      @(negedge clk);
    end
  endtask

  task automatic wait_out_full(output bit got);
    host_sel_cmd = 1'b1;
    got = 0;
    for (int i = 0; i < 50; i++) begin
      #1;
      if (host_rdata[0]) begin got = 1; return; end
      @(negedge clk);
    end
  endtask

  task automatic get(output logic [7:0] b);
    @(negedge clk);
    host_sel_cmd = 1'b0; host_rd = 1'b1;
    #1 b = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic ec_store(input logic [7:0] a, input logic [7:0] d);
    put(1, 8'h81); wait_in_empty();
    put(0, a);     wait_in_empty();
    put(0, d);     wait_in_empty();
    shadow[a] = d;
    repeat (2) @(negedge clk);
  endtask

  task automatic ec_load(input logic [7:0] a, output logic [7:0] d, output bit got);
    put(1, 8'h80); wait_in_empty();
    put(0, a);     wait_in_empty();
    wait_out_full(got);
    d = 8'h00;
    if (got) get(d);
  endtask

  task automatic status_now(output logic [7:0] s);
    @(negedge clk);
    host_sel_cmd = 1'b1;
    #1 s = host_rdata;
  endtask

  // vector: {is_store, addr, value}; loads compare against the shadow copy
  localparam logic [16:0] VEC [10] = '{
    {1'b1, 8'h12, 8'hA5}, {1'b0, 8'h12, 8'h00}, {1'b0, 8'h00, 8'h00},
    {1'b1, 8'hFF, 8'h3C}, {1'b0, 8'hFF, 8'h00}, {1'b1, 8'h00, 8'hFF},
    {1'b0, 8'h00, 8'h00}, {1'b0, 8'h80, 8'h00}, {1'b1, 8'h81, 8'h80},
    {1'b0, 8'h81, 8'h00}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d;
    bit got;
    int we0, rd0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 / R1: reset state
    status_now(s);
    check(s == 8'h00, "R9 reset status", s, 0);

    // R2: exact input-full window
    put(1, 8'h33);          // unknown opcode, harmless
    host_sel_cmd = 1'b1;
    #1 check(host_rdata == 8'h02, "R1 R2 in-full after write", host_rdata, 2);
    for (int i = 1; i < DLY; i++) begin
      @(negedge clk); #1;
      check(host_rdata[1] == 1'b1, "R2 in-full held", host_rdata[1], 1);
    end
    @(negedge clk); #1;
    check(host_rdata[1] == 1'b0, "R2 in-full dropped", host_rdata[1], 0);

    // R3 R4 R5: vector table walk
    for (int v = 0; v < 10; v++) begin
      if (VEC[v][16]) begin
        we0 = we_cnt;
        ec_store(VEC[v][15:8], VEC[v][7:0]);
        check(we_cnt == we0 + 1, "R4 one write strobe", we_cnt - we0, 1);
        check(mem[VEC[v][15:8]] == VEC[v][7:0], "R4 stored value",
              mem[VEC[v][15:8]], VEC[v][7:0]);
      end else begin
        rd0 = rd_cnt;
        ec_load(VEC[v][15:8], d, got);
        check(got, "R3 out-full rose", got, 1);
        check(d == shadow[VEC[v][15:8]], "R3 loaded byte", d, shadow[VEC[v][15:8]]);
        check(rd_cnt == rd0 + 1, "R3 one read strobe", rd_cnt - rd0, 1);
        status_now(s);
        check(s[0] == 1'b0, "R5 read clears out-full", s[0], 0);
      end
    end

    // R6: unknown opcode, then data bytes do nothing
    we0 = we_cnt; rd0 = rd_cnt;
    put(1, 8'h82); wait_in_empty();
    put(0, 8'h10); wait_in_empty();
    put(0, 8'h20); wait_in_empty();
    repeat (4) @(negedge clk);
    status_now(s);
    check(we_cnt == we0 && rd_cnt == rd0, "R6 no access after unknown opcode",
          we_cnt - we0 + rd_cnt - rd0, 0);
    check(s == 8'h00, "R6 status clean", s, 0);

    // R8: stray data byte while idle
    put(0, 8'h44); wait_in_empty();
    repeat (4) @(negedge clk);
    status_now(s);
    check(we_cnt == we0 && rd_cnt == rd0 && s == 8'h00, "R8 idle byte ignored", s, 0);

    // R7: store abandoned by a load opcode
    we0 = we_cnt;
    put(1, 8'h81); wait_in_empty();
    put(0, 8'h55); wait_in_empty();
    ec_load(8'h66, d, got);
    check(we_cnt == we0, "R7 abandoned store not written", we_cnt - we0, 0);
    check(got && d == shadow[8'h66], "R7 new load served", d, shadow[8'h66]);
    check(mem[8'h55] == shadow[8'h55], "R7 addr untouched", mem[8'h55], shadow[8'h55]);

    // R10: pending address replaced before consumption
    put(1, 8'h81); wait_in_empty();
    put(0, 8'h70);
    put(0, 8'h71); wait_in_empty();
    put(0, 8'hC3); wait_in_empty();
    repeat (2) @(negedge clk);
    check(mem[8'h71] == 8'hC3, "R10 newer addr stored", mem[8'h71], 8'hC3);
    check(mem[8'h70] == shadow[8'h70], "R10 older addr untouched", mem[8'h70], shadow[8'h70]);
    shadow[8'h71] = 8'hC3;

    // R9: reset with a pending address byte
    rd0 = rd_cnt;
    put(1, 8'h80); wait_in_empty();
    put(0, 8'h12);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    status_now(s);
    check(s == 8'h00, "R9 flags cleared", s, 0);
    put(0, 8'h13); wait_in_empty();
    repeat (6) @(negedge clk);
    status_now(s);
    check(rd_cnt == rd0 && s == 8'h00, "R9 idle after reset", rd_cnt - rd0, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule